// File: doc/BRIEF.md
# Video Active Window Timing Generator

This block drives the line timing of a scaled video output port, one pixel clock per step. Each line starts with a fixed blanking stretch in which the horizontal reference `href` is low. After it `href` stays high until the line ends. A second qualifier, `vact`, marks the span of the line that carries output samples. All positions count from the clock that follows the falling edge of `href`, and that clock is position 0.

The `vact` span depends on the output kind. For picture lines it is computed from the window begin, the window length and the ratio between the 720-sample reference line and the number of output pixels per line. Raw and sliced VBI lines use fixed spans. A free mode replaces the computed span with a programmed start and stop. A guard turns `vact` off four clocks before the line ends, whatever the mode. The computed delay can be read on `data_delay`.

All settings, including the line length, are captured once per line at the line boundary. A change made in the middle of a line therefore affects only the next line.

Top module: `vact_window_gen`

## Requirements
- R1: A line lasts the line length captured at its start. A captured value below 72 is used as 72. `href` is low at positions 0 to 63 and high from position 64 to the last position of the line.
- R2: `mode` codes 0 and 3 select picture lines. In single-clock mode, with ratio = 720 / out_pix truncated and out_pix 0 taken as 1, the delay is (win_beg+win_len)*ratio − win_len when out_pix < 720, and win_beg*ratio otherwise. `vact` is high for delay ≤ p < delay + win_len.
- R3: For picture lines in half-clock mode (`half_clk`=1), the threshold is 360 instead of 720. The delay subtracts 2*win_len, and `vact` is high for delay ≤ p < delay + 2*win_len.
- R4: `mode` code 1 is raw VBI: `vact` spans 150 ≤ p < 720 in single-clock mode. `mode` code 2 is sliced VBI: `vact` spans 726 ≤ p < 790 in single-clock mode and 662 ≤ p < 790 in half-clock mode. `data_delay` reads the start position.
- R5: Raw VBI combined with half-clock mode is not allowed: `vact` stays low for the whole line and `data_delay` reads 0.
- R6: In modes 1 and 2, with `vbi_en`=0 and free mode off, `vact` stays low for the whole line.
- R7: `vact` is low at the last four positions of every line, so it falls at least 4 clocks before the falling edge of `href`.
- R8: With `free_mode`=1, `vact` is high for free_start ≤ p < free_end in every mode, and `vbi_en` has no effect. If free_end ≤ free_start, `vact` never rises. `data_delay` still reports the computed delay.
- R9: Settings and line length are captured only at the line boundary. `data_delay` changes only at position 0 and holds for the whole line.
- R10: During reset, `href`, `vact` and `data_delay` are 0. The first line begins at position 0 one clock after reset is released, and `href` and `vact` stay low in that one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_len | input | LINE_W | Clocks per line (minimum 72) |
| mode | input | 2 | 0/3 picture, 1 raw VBI, 2 sliced VBI |
| half_clk | input | 1 | Half-clock output mode |
| vbi_en | input | 1 | Allow `vact` on VBI lines |
| free_mode | input | 1 | Use programmed start/stop for `vact` |
| win_beg | input | PIX_W | Window horizontal begin |
| win_len | input | PIX_W | Window horizontal length |
| out_pix | input | PIX_W | Output pixels per line |
| free_start | input | PIX_W | Free-mode start position (0..864) |
| free_end | input | PIX_W | Free-mode stop position (0..864) |
| href | output | 1 | Horizontal reference |
| vact | output | 1 | Video-active qualifier |
| data_delay | output | PIX_W+11 | Computed delay captured for the current line |

## Verification
The bench targets the edges of the scaling formula. These are out_pix at exactly 720 and 360, where the two formulas meet, out_pix of 0, and ratios that truncate to 0. A design with the wrong comparison or the wrong subtraction factor places `vact` off by a window length or more. Windows longer than the line check the four-clock guard: a design without it keeps `vact` high into the `href` falling edge. Inverted start/stop values in free mode, VBI suppression with free mode on and off, and raw VBI in half-clock mode each expose a design that asserts `vact` when it must stay silent. New settings are driven a few clocks into each line, so a design that does not capture at the boundary shows a mixed line.

// File: rtl/vawg_pkg.sv
package vawg_pkg;

  localparam int unsigned HREF_BLANK      = 64;
  localparam int unsigned CUTOFF          = 4;
  localparam int unsigned SCALE_REF       = 720;
  localparam int unsigned HALF_REF        = 360;
  localparam int unsigned RAW_BEG         = 150;
  localparam int unsigned RAW_END         = 720;
  localparam int unsigned SLICED_BEG      = 726;
  localparam int unsigned SLICED_HALF_BEG = 662;
  localparam int unsigned SLICED_END      = 790;
  localparam int unsigned MIN_LINE        = 72;

  typedef enum logic [1:0] {
    MODE_VIDEO  = 2'd0,
    MODE_RAW    = 2'd1,
    MODE_SLICED = 2'd2,
    MODE_RSVD   = 2'd3
  } vmode_e;

  typedef struct packed {
    logic [31:0] dly;
    logic [31:0] beg;
    logic [31:0] fin;
    logic        en;
  } win_t;

  function automatic int unsigned ratio_of(int unsigned npix);
    return SCALE_REF / ((npix == 0) ? 1 : npix);
  endfunction

  // picture-line delay, truncating integer arithmetic
  function automatic int unsigned video_delay(int unsigned hbeg, int unsigned hlen,
                                              int unsigned npix, logic half);
    int unsigned r   = ratio_of(npix);
    int unsigned thr = half ? HALF_REF : SCALE_REF;
    int unsigned k   = half ? 2 : 1;
    if (npix < thr) return (hbeg + hlen) * r - k * hlen;
    return hbeg * r;
  endfunction

  function automatic win_t window_calc(vmode_e mode, logic half, logic vbi_en, logic free,
                                       int unsigned hbeg, int unsigned hlen, int unsigned npix,
                                       int unsigned fstart, int unsigned fend);
    win_t w;
    int unsigned k = half ? 2 : 1;
    case (mode)
      MODE_RAW: begin
        w.dly = half ? 0 : RAW_BEG;
        w.fin = half ? 0 : RAW_END;
        w.en  = vbi_en && !half;
      end
      MODE_SLICED: begin
        w.dly = half ? SLICED_HALF_BEG : SLICED_BEG;
        w.fin = SLICED_END;
        w.en  = vbi_en;
      end
      default: begin
        w.dly = video_delay(hbeg, hlen, npix, half);
        w.fin = w.dly + k * hlen;
        w.en  = 1'b1;
      end
    endcase
    w.beg = w.dly;
    if (free) begin
      w.beg = fstart;
      w.fin = fend;
      w.en  = 1'b1;
    end
    return w;
  endfunction

endpackage

// File: rtl/vawg_line_ctr.sv
module vawg_line_ctr #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] len_q,
  output logic [LINE_W-1:0] pos,
  output logic              pend,
  output logic              load,
  output logic              line_start
);
  // load fires once after reset and on the last clock of each line
  assign load       = pend || (pos == len_q - LINE_W'(1));
  assign line_start = !pend && (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b1;
      pos  <= '0;
    end else if (load) begin
      pend <= 1'b0;
      pos  <= '0;
    end else begin
      pos  <= pos + LINE_W'(1);
    end
  end
endmodule

// File: rtl/vawg_shadow.sv
module vawg_shadow
  import vawg_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 11,
  parameter int DW     = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINE_W-1:0] line_len,
  input  vmode_e            mode,
  input  logic              half_clk,
  input  logic              vbi_en,
  input  logic              free_mode,
  input  logic [PIX_W-1:0]  win_beg,
  input  logic [PIX_W-1:0]  win_len,
  input  logic [PIX_W-1:0]  out_pix,
  input  logic [PIX_W-1:0]  free_start,
  input  logic [PIX_W-1:0]  free_end,
  output logic [LINE_W-1:0] len_q,
  output logic [DW-1:0]     dly_q,
  output logic [DW-1:0]     beg_q,
  output logic [DW-1:0]     fin_q,
  output logic              en_q,
  output vmode_e            mode_q,
  output logic              vbi_en_q,
  output logic              free_q
);
  localparam logic [LINE_W-1:0] LEN_MIN = LINE_W'(MIN_LINE);

  win_t              w;
  logic [LINE_W-1:0] len_c;

  always_comb begin
    w = window_calc(mode, half_clk, vbi_en, free_mode,
                    32'(win_beg), 32'(win_len), 32'(out_pix),
                    32'(free_start), 32'(free_end));
    len_c = (line_len < LEN_MIN) ? LEN_MIN : line_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q    <= LEN_MIN;
      dly_q    <= '0;
      beg_q    <= '0;
      fin_q    <= '0;
      en_q     <= 1'b0;
      mode_q   <= MODE_VIDEO;
      vbi_en_q <= 1'b0;
      free_q   <= 1'b0;
    end else if (load) begin
      len_q    <= len_c;
      dly_q    <= DW'(w.dly);
      beg_q    <= DW'(w.beg);
      fin_q    <= DW'(w.fin);
      en_q     <= w.en;
      mode_q   <= mode;
      vbi_en_q <= vbi_en;
      free_q   <= free_mode;
    end
  end
endmodule

// File: rtl/vawg_gate.sv
module vawg_gate
  import vawg_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int DW     = 21
) (
  input  logic [LINE_W-1:0] pos,
  input  logic              pend,
  input  logic [LINE_W-1:0] len_q,
  input  logic [DW-1:0]     beg_q,
  input  logic [DW-1:0]     fin_q,
  input  logic              en_q,
  output logic              href,
  output logic              vact
);
  logic in_win;
  logic before_cut;

  always_comb begin
    in_win     = (32'(pos) >= 32'(beg_q)) && (32'(pos) < 32'(fin_q));
    before_cut = (32'(pos) + CUTOFF) < 32'(len_q);
    href       = !pend && (32'(pos) >= HREF_BLANK);
    vact       = !pend && en_q && in_win && before_cut;
  end
endmodule

// File: rtl/vact_window_gen.sv
module vact_window_gen
  import vawg_pkg::*;
#(
  parameter  int PIX_W  = 10,
  parameter  int LINE_W = 11,
  localparam int DW     = PIX_W + 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_len,
  input  logic [1:0]        mode,
  input  logic              half_clk,
  input  logic              vbi_en,
  input  logic              free_mode,
  input  logic [PIX_W-1:0]  win_beg,
  input  logic [PIX_W-1:0]  win_len,
  input  logic [PIX_W-1:0]  out_pix,
  input  logic [PIX_W-1:0]  free_start,
  input  logic [PIX_W-1:0]  free_end,
  output logic              href,
  output logic              vact,
  output logic [DW-1:0]     data_delay
);
  logic [LINE_W-1:0] pos;
  logic              pend;
  logic              load;
  logic              line_start;
  logic [LINE_W-1:0] len_q;
  logic [DW-1:0]     dly_q;
  logic [DW-1:0]     beg_q;
  logic [DW-1:0]     fin_q;
  logic              en_q;
  vmode_e            mode_q;
  logic              vbi_en_q;
  logic              free_q;

  vawg_line_ctr #(.LINE_W(LINE_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .len_q(len_q),
    .pos(pos), .pend(pend), .load(load), .line_start(line_start)
  );

  vawg_shadow #(.PIX_W(PIX_W), .LINE_W(LINE_W), .DW(DW)) shd_i (
    .clk(clk), .rst_n(rst_n), .load(load), .line_len(line_len),
    .mode(vmode_e'(mode)), .half_clk(half_clk), .vbi_en(vbi_en), .free_mode(free_mode),
    .win_beg(win_beg), .win_len(win_len), .out_pix(out_pix),
    .free_start(free_start), .free_end(free_end),
    .len_q(len_q), .dly_q(dly_q), .beg_q(beg_q), .fin_q(fin_q), .en_q(en_q),
    .mode_q(mode_q), .vbi_en_q(vbi_en_q), .free_q(free_q)
  );

  vawg_gate #(.LINE_W(LINE_W), .DW(DW)) gate_i (
    .pos(pos), .pend(pend), .len_q(len_q), .beg_q(beg_q), .fin_q(fin_q),
    .en_q(en_q), .href(href), .vact(vact)
  );

  assign data_delay = dly_q;
endmodule

// File: rtl/vact_window_gen_chk.sv
module vact_window_gen_chk
  import vawg_pkg::*;
#(
  parameter int DW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          href,
  input logic          vact,
  input logic [DW-1:0] data_delay,
  input logic          line_start,
  input logic          pend,
  input vmode_e        mode_q,
  input logic          vbi_en_q,
  input logic          free_q
);
  logic [15:0] low_run;
  logic        armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run <= '0;
      armed   <= 1'b0;
    end else begin
      low_run <= href ? '0 : low_run + 16'd1;
      armed   <= armed | href;
    end
  end

  a_r1_href_low_64: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(href)) |-> (low_run == 16'(HREF_BLANK)));

  a_r7_vact_clear_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(href) |-> (!$past(vact, 1) && !$past(vact, 2) && !$past(vact, 3) && !$past(vact, 4)));

  a_r6_vbi_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_q && !vbi_en_q && (mode_q == MODE_RAW || mode_q == MODE_SLICED)) |-> !vact);

  a_r9_delay_moves_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (data_delay != $past(data_delay)) |-> line_start);

  a_r10_quiet_before_first_line: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (!href && !vact));
endmodule

bind vact_window_gen vact_window_gen_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .href(href), .vact(vact), .data_delay(data_delay),
  .line_start(line_start), .pend(pend), .mode_q(mode_q), .vbi_en_q(vbi_en_q),
  .free_q(free_q)
);

// File: tb/vact_window_gen_tb_top.sv
module vact_window_gen_tb_top;
  localparam int PIX_W  = 10;
  localparam int LINE_W = 11;
  localparam int DW     = PIX_W + 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LINE_W-1:0] line_len = '0;
  logic [1:0]        mode = '0;
  logic              half_clk = 1'b0, vbi_en = 1'b0, free_mode = 1'b0;
  logic [PIX_W-1:0]  win_beg = '0, win_len = '0, out_pix = '0, free_start = '0, free_end = '0;
  logic              href, vact;
  logic [DW-1:0]     data_delay;

  always #5 clk = ~clk;

  vact_window_gen #(.PIX_W(PIX_W), .LINE_W(LINE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_len(line_len), .mode(mode), .half_clk(half_clk),
    .vbi_en(vbi_en), .free_mode(free_mode), .win_beg(win_beg), .win_len(win_len),
    .out_pix(out_pix), .free_start(free_start), .free_end(free_end),
    .href(href), .vact(vact), .data_delay(data_delay)
  );

  typedef struct {
    int    len;
    int    md;
    bit    half, vbi, free;
    int    hb, hl, np, fs, fe;
    string tag;
  } cfg_t;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int eff_len(cfg_t c);
    return (c.len < 72) ? 72 : c.len;
  endfunction

  // the two scaling branches written out from R2/R3
  function automatic int delay_of(cfg_t c);
    int q, lim, mult;
    if (c.md == 1) return c.half ? 0 : 150;
    if (c.md == 2) return c.half ? 662 : 726;
    q    = 720 / ((c.np == 0) ? 1 : c.np);
    lim  = c.half ? 360 : 720;
    mult = c.half ? 2 : 1;
    if (c.np >= lim) return c.hb * q;
    return c.hb * q + c.hl * q - mult * c.hl;
  endfunction

  function automatic bit vact_at(cfg_t c, int p);
    int st, en;
    bit on;
    if (c.free) begin
      on = 1; st = c.fs; en = c.fe;
    end else if (c.md == 1) begin
      on = c.vbi && !c.half; st = 150; en = 720;
    end else if (c.md == 2) begin
      on = c.vbi; st = c.half ? 662 : 726; en = 790;
    end else begin
      on = 1; st = delay_of(c); en = st + (c.half ? 2 : 1) * c.hl;
    end
    return on && (p >= st) && (p < en) && (p + 4 < eff_len(c));
  endfunction

  task automatic apply(cfg_t c);
    line_len   = LINE_W'(c.len);
    mode       = 2'(c.md);
    half_clk   = c.half;
    vbi_en     = c.vbi;
    free_mode  = c.free;
    win_beg    = PIX_W'(c.hb);
    win_len    = PIX_W'(c.hl);
    out_pix    = PIX_W'(c.np);
    free_start = PIX_W'(c.fs);
    free_end   = PIX_W'(c.fe);
  endtask

  // entered at the negedge of position 0; leaves at position 0 of the next line
  task automatic run_line(cfg_t cur, cfg_t nxt);
    int L = eff_len(cur);
    int hp = -1, vp = -1, hv = 0, vv = 0;
    int dexp = delay_of(cur);
    for (int p = 0; p < L; p++) begin
      if (p == 2) apply(nxt);
      if (p == 0) chk(int'(data_delay) == dexp, cur.tag, "data_delay at line start", int'(data_delay), dexp);
      if (p == L - 1) chk(int'(data_delay) == dexp, "R9", "data_delay at line end", int'(data_delay), dexp);
      if (hp < 0 && href != (p >= 64)) begin hp = p; hv = href; end
      if (vp < 0 && vact != vact_at(cur, p)) begin vp = p; vv = vact; end
      @(negedge clk);
    end
    chk(hp < 0, "R1", $sformatf("href at position %0d", hp), hv, int'(!hv));
    chk(vp < 0, cur.tag, $sformatf("vact at position %0d", vp), vv, int'(!vv));
  endtask

  function automatic cfg_t mk(string tag, int len, int md, bit half, bit vbi, bit free,
                              int hb, int hl, int np, int fs, int fe);
    cfg_t c;
    c.tag = tag; c.len = len; c.md = md; c.half = half; c.vbi = vbi; c.free = free;
    c.hb = hb; c.hl = hl; c.np = np; c.fs = fs; c.fe = fe;
    return c;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cfg_t q[$];
    int np_opts[8] = '{0, 180, 360, 480, 640, 720, 800, 1000};
    void'($urandom(32'd4242));
    q.push_back(mk("R2", 600, 0, 0, 1, 0, 40, 100, 720, 0, 0));
    q.push_back(mk("R2", 600, 0, 0, 1, 0, 10, 50, 360, 0, 0));
    q.push_back(mk("R2", 800, 0, 0, 1, 0, 0, 1, 0, 0, 0));
    q.push_back(mk("R2", 500, 3, 0, 1, 0, 30, 200, 640, 0, 0));
    q.push_back(mk("R2", 500, 0, 0, 1, 0, 70, 90, 1000, 0, 0));
    q.push_back(mk("R3", 600, 0, 1, 1, 0, 20, 30, 180, 0, 0));
    q.push_back(mk("R3", 600, 0, 1, 1, 0, 50, 100, 400, 0, 0));
    q.push_back(mk("R3", 600, 0, 1, 1, 0, 50, 60, 360, 0, 0));
    q.push_back(mk("R4", 900, 1, 0, 1, 0, 0, 0, 720, 0, 0));
    q.push_back(mk("R4", 900, 2, 0, 1, 0, 0, 0, 720, 0, 0));
    q.push_back(mk("R4", 900, 2, 1, 1, 0, 0, 0, 720, 0, 0));
    q.push_back(mk("R5", 900, 1, 1, 1, 0, 0, 0, 720, 0, 0));
    q.push_back(mk("R6", 900, 2, 0, 0, 0, 0, 0, 720, 0, 0));
    q.push_back(mk("R6", 900, 1, 0, 0, 0, 0, 0, 720, 0, 0));
    q.push_back(mk("R7", 400, 0, 0, 1, 0, 100, 700, 720, 0, 0));
    q.push_back(mk("R7", 500, 1, 0, 1, 0, 0, 0, 720, 0, 0));
    q.push_back(mk("R1", 40, 0, 0, 1, 0, 10, 100, 720, 0, 0));
    q.push_back(mk("R8", 600, 0, 0, 1, 1, 10, 20, 720, 300, 200));
    q.push_back(mk("R8", 900, 0, 0, 1, 1, 10, 20, 720, 0, 864));
    q.push_back(mk("R8", 500, 2, 0, 0, 1, 0, 0, 720, 120, 340));
    for (int i = 0; i < 45; i++) begin
      cfg_t c;
      c.md   = int'($urandom % 4);
      c.half = 1'($urandom % 2);
      c.vbi  = ($urandom % 4) != 0;
      c.free = ($urandom % 5) == 0;
      c.hb   = int'($urandom % 400);
      c.hl   = 1 + int'($urandom % 500);
      c.np   = (($urandom % 3) == 0) ? int'($urandom % 1024) : np_opts[$urandom % 8];
      c.fs   = int'($urandom % 865);
      c.fe   = int'($urandom % 865);
      c.len  = 100 + int'($urandom % 900);
      c.tag  = c.free ? "R8" : (c.md == 1 && c.half) ? "R5" :
               (c.md inside {1, 2} && !c.vbi) ? "R6" :
               (c.md inside {1, 2}) ? "R4" : c.half ? "R3" : "R2";
      q.push_back(c);
    end
    q.push_back(mk("R9", 300, 0, 0, 1, 0, 0, 0, 720, 0, 0));

    apply(q[0]);
    repeat (4) @(negedge clk);
    chk(href == 1'b0, "R10", "href in reset", int'(href), 0);
    chk(vact == 1'b0, "R10", "vact in reset", int'(vact), 0);
    chk(data_delay == '0, "R10", "data_delay in reset", int'(data_delay), 0);
    rst_n = 1'b1;
    chk(href == 1'b0 && vact == 1'b0, "R10", "outputs in load clock", int'({href, vact}), 0);
    @(negedge clk);
    for (int i = 0; i + 1 < q.size(); i++) run_line(q[i], q[i + 1]);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule